// File: doc/BRIEF.md
# Fixed-Base Delta Word Codec

This block shrinks memory words one at a time by comparing each word with a constant reference, the midpoint of the unsigned word range (2^(W-1) for a W-bit word). The reference is never taken from the data. If the signed difference between a word and this reference fits in a narrow two's-complement offset, the block emits only that offset and sets a marker bit. If it does not fit, the block emits the word unchanged and clears the marker.

Compression is a two-stage pipeline. The first stage tests whether the word lies in range. The second stage subtracts the reference and forms the entry. A separate one-stage expander reverses the mapping: it sign-extends a marked offset and adds the reference back, and it passes an unmarked entry through unchanged. Both paths use valid/ready streaming. They stall without loss when the consumer is not ready, and they take one item per cycle when they are not stalled. Packing entries into lines and choosing the reference adaptively are left to the surrounding logic.

An entry is W+1 bits. Bit W is the marker. For a marked entry, bits OFS_W-1..0 hold the offset and the bits between them are zero. For an unmarked entry, bits W-1..0 hold the raw word. A length output reports how many entry bits are meaningful.

Top module: `fbd_codec`

## Requirements
- R1: A word in the range 2^(W-1)-128 to 2^(W-1)+127 inclusive produces an entry with bit W = 1, bits 7..0 = the low 8 bits of (word - 2^(W-1)), bits W-1..8 = 0, and a length of 9.
- R2: Any other word produces an entry with bit W = 0, bits W-1..0 = the word, and a length of W+1.
- R3: The range edges behave exactly: 2^(W-1)-128 and 2^(W-1)+127 compress, while 2^(W-1)-129 and 2^(W-1)+128 stay raw.
- R4: A word accepted at a clock edge shows on the compressed output after the second following edge. While the output is ready, the input stays ready every cycle, so one word is taken per cycle.
- R5: While the compressed output is valid and not ready, it stays valid and its entry and length do not change. Words leave in the order they arrived, and none is lost.
- R6: The expander outputs the sign-extended offset plus 2^(W-1) for an entry with bit W = 1, and bits W-1..0 unchanged for an entry with bit W = 0, one edge after acceptance.
- R7: Compressing any word and then expanding the entry returns the original word exactly.
- R8: During reset and on the first cycle after it, both output valids are low. Once reset is released, both input readys are high.
- R9: While the expander output is valid and not ready, it stays valid and its word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cin_valid | input | 1 | A word is offered for compression |
| cin_ready | output | 1 | The compressor can take a word |
| cin_word | input | WORD_W | Word to compress |
| cout_valid | output | 1 | A compressed entry is available |
| cout_ready | input | 1 | The consumer takes the entry |
| cout_entry | output | WORD_W+1 | Marker bit followed by an offset or a raw word |
| cout_len | output | LEN_W | Number of meaningful entry bits (OFS_W+1 or WORD_W+1) |
| din_valid | input | 1 | An entry is offered for expansion |
| din_ready | output | 1 | The expander can take an entry |
| din_entry | input | WORD_W+1 | Entry to expand |
| dout_valid | output | 1 | A restored word is available |
| dout_ready | input | 1 | The consumer takes the word |
| dout_word | output | WORD_W | Restored word |

## Verification
If the range test or the subtraction is wrong, the fault shows on the entry two edges after the bad word is accepted: a wrong marker, a wrong length, or nonzero filler bits. If a stall flag or a valid bit is wrong, words are dropped, duplicated or changed while the output waits. The bench sees this either as a changing entry on the next stalled cycle or as an order mismatch the next time the chained expander gives back a word. An error in the expander's sign extension shows only on words below the reference, one edge after their entry is taken, so the stimulus includes values on both sides of the reference and right at the range edges.

// File: rtl/fbd_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the fixed-base delta codec.
// Assumes: the word width is wider than the offset width.
package fbd_pkg;
    localparam int DEF_WORD_W = 64;
    localparam int DEF_OFS_W  = 8;

    // Value of the marker bit at the top of each entry
    typedef enum logic {
        KIND_RAW = 1'b0,
        KIND_CMP = 1'b1
    } kind_e;
endpackage

// File: rtl/fbd_range_stage.sv
`timescale 1ns/1ps
// First compression stage: registers the word along with a flag that says
// whether the word lies within the offset span around the midpoint reference.
// Assumes: OFS_W >= 2 and WORD_W > OFS_W; standard valid/ready register slice.
module fbd_range_stage #(
    parameter int WORD_W = 64,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic              out_fit
);
    localparam logic [WORD_W-1:0] BASE = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] SPAN = WORD_W'(1) << (OFS_W-1);
    localparam logic [WORD_W-1:0] LO   = BASE - SPAN;
    localparam logic [WORD_W-1:0] HI   = BASE + SPAN - WORD_W'(1);

    logic fit_now;

    // Accept whenever the slot is empty or is being emptied this cycle
    assign in_ready = !out_valid || out_ready;

    // Unsigned window test around the reference
    always_comb begin
        fit_now = (in_word >= LO) && (in_word <= HI);
    end

    // Track occupancy of the slot
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // Capture the word and its range flag on a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_fit  <= 1'b0;
        end else if (in_valid && in_ready) begin
            out_word <= in_word;
            out_fit  <= fit_now;
        end
    end

    AST_S1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_fit))); // R5
endmodule

// File: rtl/fbd_encode_stage.sv
`timescale 1ns/1ps
// Second compression stage: subtracts the reference from in-range words and
// builds the entry (marker, offset or raw word) together with its bit length.
// Assumes: the in_fit flag was produced by the range stage for in_word.
module fbd_encode_stage
    import fbd_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int OFS_W  = 8,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_fit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W:0]   out_entry,
    output logic [LEN_W-1:0]  out_len
);
    localparam logic [WORD_W-1:0] BASE    = {1'b1, {(WORD_W-1){1'b0}}};
    localparam int                PAD_W   = WORD_W - OFS_W;
    localparam logic [LEN_W-1:0]  LEN_CMP = LEN_W'(OFS_W + 1);
    localparam logic [LEN_W-1:0]  LEN_RAW = LEN_W'(WORD_W + 1);

    logic [WORD_W-1:0] delta;
    logic [WORD_W:0]   entry_next;

    // Accept whenever the slot is empty or is being emptied this cycle
    assign in_ready = !out_valid || out_ready;

    // Form the entry from the difference or from the raw word
    always_comb begin
        delta = in_word - BASE;
        if (in_fit) entry_next = {KIND_CMP, {PAD_W{1'b0}}, delta[OFS_W-1:0]};
        else        entry_next = {KIND_RAW, in_word};
    end

    // Track occupancy of the slot
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // Capture the entry and its length on a transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_entry <= '0;
            out_len   <= '0;
        end else if (in_valid && in_ready) begin
            out_entry <= entry_next;
            out_len   <= in_fit ? LEN_CMP : LEN_RAW;
        end
    end

    AST_CMP_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_fit) |=>
            (out_entry[WORD_W] && out_entry[OFS_W-1:0] == $past(in_word[OFS_W-1:0]))); // R1
    AST_RAW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_fit) |=> (out_entry == {1'b0, $past(in_word)})); // R2
    AST_S2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_entry) && $stable(out_len))); // R5
endmodule

// File: rtl/fbd_expand_stage.sv
`timescale 1ns/1ps
// Expander: restores a word from an entry. It sign-extends a marked offset and
// adds the reference; an unmarked payload passes through. One register stage.
// Assumes: entries use the layout that the encode stage produces.
module fbd_expand_stage #(
    parameter int WORD_W = 64,
    parameter int OFS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W:0]   in_entry,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    localparam logic [WORD_W-1:0] BASE = {1'b1, {(WORD_W-1){1'b0}}};
    localparam int                EXT_W = WORD_W - OFS_W;

    logic [WORD_W-1:0] offset_ext;
    logic [WORD_W-1:0] word_next;

    // Accept whenever the slot is empty or is being emptied this cycle
    assign in_ready = !out_valid || out_ready;

    // Rebuild the word from either kind of entry
    always_comb begin
        offset_ext = {{EXT_W{in_entry[OFS_W-1]}}, in_entry[OFS_W-1:0]};
        word_next  = in_entry[WORD_W] ? (offset_ext + BASE) : in_entry[WORD_W-1:0];
    end

    // Track occupancy of the slot
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // Capture the restored word on a transfer
    always_ff @(posedge clk) begin
        if (!rst_n)                      out_word <= '0;
        else if (in_valid && in_ready)   out_word <= word_next;
    end

    AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_entry[WORD_W]) |=> (out_word == $past(in_entry[WORD_W-1:0]))); // R6
    AST_CMP_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_entry[WORD_W]) |=> (out_word[OFS_W-1:0] == $past(in_entry[OFS_W-1:0]))); // R6
    AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R9
endmodule

// File: rtl/fbd_codec.sv
`timescale 1ns/1ps
// Top of the fixed-base delta codec: a two-stage compressor (range test, then
// subtract and encode) and an independent one-stage expander.
// Assumes: synchronous active-low reset; both paths use valid/ready streaming.
module fbd_codec
    import fbd_pkg::*;
#(
    parameter  int WORD_W = DEF_WORD_W,
    parameter  int OFS_W  = DEF_OFS_W,
    localparam int LEN_W  = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cin_valid,
    output logic              cin_ready,
    input  logic [WORD_W-1:0] cin_word,
    output logic              cout_valid,
    input  logic              cout_ready,
    output logic [WORD_W:0]   cout_entry,
    output logic [LEN_W-1:0]  cout_len,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [WORD_W:0]   din_entry,
    output logic              dout_valid,
    input  logic              dout_ready,
    output logic [WORD_W-1:0] dout_word
);
    logic              s1_valid;
    logic              s1_ready;
    logic [WORD_W-1:0] s1_word;
    logic              s1_fit;

    fbd_range_stage #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_range (
        .clk(clk), .rst_n(rst_n),
        .in_valid(cin_valid), .in_ready(cin_ready), .in_word(cin_word),
        .out_valid(s1_valid), .out_ready(s1_ready), .out_word(s1_word), .out_fit(s1_fit)
    );

    fbd_encode_stage #(.WORD_W(WORD_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_encode (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s1_valid), .in_ready(s1_ready), .in_word(s1_word), .in_fit(s1_fit),
        .out_valid(cout_valid), .out_ready(cout_ready),
        .out_entry(cout_entry), .out_len(cout_len)
    );

    fbd_expand_stage #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_expand (
        .clk(clk), .rst_n(rst_n),
        .in_valid(din_valid), .in_ready(din_ready), .in_entry(din_entry),
        .out_valid(dout_valid), .out_ready(dout_ready), .out_word(dout_word)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!cout_valid && !dout_valid)); // R8
    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cout_ready && $past(rst_n)) |-> cin_ready); // R4
endmodule

// File: tb/tb_fbd_codec.sv
`timescale 1ns/1ps
module tb_fbd_codec;
    localparam int W = 64;
    localparam logic [W-1:0] BASE = 64'h8000_0000_0000_0000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cin_valid = 1'b0;
    logic         cin_ready;
    logic [W-1:0] cin_word = '0;
    logic         cout_valid;
    logic [W:0]   cout_entry;
    logic [6:0]   cout_len;
    logic         din_ready;
    logic         dout_valid;
    logic         dout_ready = 1'b1;
    logic [W-1:0] dout_word;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    int dout_fires = 0;

    always #10 clk = ~clk;

    // Compressor output is chained into the expander for round trips
    fbd_codec dut (
        .clk(clk), .rst_n(rst_n),
        .cin_valid(cin_valid), .cin_ready(cin_ready), .cin_word(cin_word),
        .cout_valid(cout_valid), .cout_ready(din_ready),
        .cout_entry(cout_entry), .cout_len(cout_len),
        .din_valid(cout_valid), .din_ready(din_ready), .din_entry(cout_entry),
        .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_word(dout_word)
    );

    // Vector: {word, marker, offset}
    localparam logic [72:0] VEC [12] = '{
        {64'h7FFF_FFFF_FFFF_FF80, 1'b1, 8'h80},
        {64'h8000_0000_0000_007F, 1'b1, 8'h7F},
        {64'h7FFF_FFFF_FFFF_FF7F, 1'b0, 8'h00},
        {64'h8000_0000_0000_0080, 1'b0, 8'h00},
        {64'h8000_0000_0000_0000, 1'b1, 8'h00},
        {64'h0000_0000_0000_0000, 1'b0, 8'h00},
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 8'h00},
        {64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 8'hFF},
        {64'h8000_0000_0000_0001, 1'b1, 8'h01},
        {64'h0000_0000_0000_0080, 1'b0, 8'h00},
        {64'hFFFF_FFFF_FFFF_FF80, 1'b0, 8'h00},
        {64'h8000_0001_0000_0000, 1'b0, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected entry derived from R1/R2
    function automatic logic [W:0] model_entry(input logic [W-1:0] w);
        logic signed [W-1:0] d;
        d = $signed(w - BASE);
        if (d >= -128 && d <= 127) return {1'b1, 56'h0, d[7:0]};
        return {1'b0, w};
    endfunction

    function automatic logic [6:0] model_len(input logic [W-1:0] w);
        return model_entry(w)[W] ? 7'd9 : 7'd65;
    endfunction

    logic [W-1:0] q_c[$];
    logic [W-1:0] q_d[$];
    bit           c_stall = 1'b0;
    logic [W:0]   c_prev;
    bit           d_stall = 1'b0;
    logic [W-1:0] d_prev;

    // Scoreboard for streaming phases, sampled away from the active edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (c_stall) chk(cout_valid && cout_entry == c_prev, "R5 stall hold", cout_entry, c_prev);
            if (d_stall) chk(dout_valid && dout_word == d_prev, "R9 stall hold", {1'b0, dout_word}, {1'b0, d_prev});
            if (cout_valid && din_ready) begin
                logic [W-1:0] w;
                w = (q_c.size() > 0) ? q_c.pop_front() : '0;
                chk(cout_entry == model_entry(w), "R1 R2 R5 stream entry", cout_entry, model_entry(w));
                chk(cout_len == model_len(w), "R1 R2 stream len", {58'h0, cout_len}, {58'h0, model_len(w)});
                q_d.push_back(w);
            end
            if (dout_valid && dout_ready) begin
                logic [W-1:0] w;
                w = (q_d.size() > 0) ? q_d.pop_front() : '0;
                chk(dout_word == w, "R7 round trip", {1'b0, dout_word}, {1'b0, w});
                dout_fires++;
            end
            if (cin_valid && cin_ready) q_c.push_back(cin_word);
            c_stall = cout_valid && !din_ready;
            c_prev  = cout_entry;
            d_stall = dout_valid && !dout_ready;
            d_prev  = dout_word;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL R4 watchdog actual=%0d expected<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // Reset state, R8
        repeat (3) @(negedge clk);
        chk(!cout_valid && !dout_valid, "R8 valids low in reset", {63'h0, cout_valid, dout_valid}, '0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!cout_valid && !dout_valid, "R8 valids low after reset", {63'h0, cout_valid, dout_valid}, '0);
        chk(cin_ready && din_ready, "R8 readys high", {63'h0, cin_ready, din_ready}, 65'd3);

        // Table walk: R1 R2 R3 R4 R6
        for (int i = 0; i < 12; i++) begin
            logic [W-1:0] w;
            logic [W:0]   exp_e;
            int           n;
            w = VEC[i][72:9];
            exp_e = VEC[i][8] ? {1'b1, 56'h0, VEC[i][7:0]} : {1'b0, w};
            @(posedge clk); #1 cin_valid = 1'b1; cin_word = w;
            @(negedge clk);
            chk(cin_ready, "R4 input ready", {64'h0, cin_ready}, 65'd1);
            @(posedge clk); #1 cin_valid = 1'b0;
            n = 0;
            do begin @(negedge clk); n++; end while (!cout_valid && n < 8);
            chk(n == 2, "R4 latency", n, 2);
            chk(cout_entry == exp_e, "R1 R2 R3 table entry", cout_entry, exp_e);
            chk(cout_len == (VEC[i][8] ? 7'd9 : 7'd65), "R1 R2 R3 table len", {58'h0, cout_len},
                VEC[i][8] ? 65'd9 : 65'd65);
            n = 0;
            do begin @(negedge clk); n++; end while (!dout_valid && n < 8);
            chk(n == 1, "R6 expander latency", n, 1);
            chk(dout_word == w, "R6 R7 table restore", {1'b0, dout_word}, {1'b0, w});
            @(negedge clk);
        end

        // Back-to-back stream: R4
        mon_en = 1'b1;
        dout_fires = 0;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk); #1 cin_valid = 1'b1;
            cin_word = BASE + 64'(i * 37) - 64'd200;
            @(negedge clk);
            chk(cin_ready, "R4 one word per cycle", {64'h0, cin_ready}, 65'd1);
        end
        @(posedge clk); #1 cin_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(dout_fires == 16, "R4 all streamed words out", dout_fires, 16);

        // Random stream with backpressure: R5 R7 R9
        for (int acc = 0; acc < 400; ) begin
            @(posedge clk); #1;
            dout_ready = ($urandom_range(9) < 6);
            if (!(cin_valid && !cin_ready_q)) begin
                cin_valid = ($urandom_range(3) != 0);
                if ($urandom_range(1) == 1) cin_word = {$urandom, $urandom};
                else cin_word = BASE + 64'($urandom_range(600)) - 64'd300;
            end
            @(negedge clk);
            cin_ready_q = cin_ready;
            if (cin_valid && cin_ready) acc++;
        end
        @(posedge clk); #1 cin_valid = 1'b0; dout_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk(q_c.size() == 0 && q_d.size() == 0, "R5 no word lost", q_c.size() + q_d.size(), 0);
        mon_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    bit cin_ready_q = 1'b1;
endmodule